// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block buffers 9-bit words between two clock domains. The producer writes on its own clock and the consumer reads on a separate clock. The two clocks may be tied together or may be unrelated. Each port is gated by a pair of enables, and a transfer happens only when both enables of that port are high. The read port holds the most recently read word on its output register until the next read.

Four status flags report the fill level. An empty flag and an almost-empty flag are computed in the read domain. A full flag and an almost-full flag are computed in the write domain. The almost-empty and almost-full levels come from two offset registers, and both offsets default to 7 after reset. While the load input is high, write cycles stop filling the buffer. Each one stores the data word into the offset register that a small sequencer selects. The sequencer then steps to the next register, so a session may rewrite one offset, both offsets, or keep cycling.

Pointers cross between the domains as Gray codes through two-flop synchronizers. The storage is an inferred dual-port RAM whose depth is a power-of-two parameter.

Top module: `dcfifo_pflag`

## Requirements
- R1: Words leave the read port in the same order they were written. Each word appears on rdata_o at the read-clock edge that performs its read.
- R2: A word is stored only on a write-clock edge where wen_a_i and wen_b_i are both high and load_i is low. A single write enable has no effect.
- R3: A read happens only on a read-clock edge where ren_a_i and ren_b_i are both high. A single read enable leaves rdata_o and the fill level unchanged.
- R4: empty_o is high when the buffer holds no words. A read request while empty is ignored: rdata_o holds its value and the next stored word is the next one read.
- R5: full_o is high when the buffer holds DEPTH words. A write request while full is ignored and corrupts no stored word.
- R6: aempty_o is high whenever the fill level is less than or equal to the almost-empty offset.
- R7: afull_o is high whenever the fill level is greater than or equal to DEPTH minus the almost-full offset.
- R8: While load_i is high, each write cycle with both write enables stores the low bits of wdata_i (bits 6:0 for DEPTH 64) into the selected offset register instead of the buffer. The selection order is the almost-empty offset first, then the almost-full offset, then wrapping back to the first.
- R9: Dropping load_i returns the sequencer to the almost-empty offset. A session that writes only the first offset leaves the almost-full offset unchanged.
- R10: Reset (rst_ni low) empties the buffer, clears rdata_o to 0, and restores both offsets to 7. After reset, empty_o and aempty_o are high, and full_o and afull_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low, both domains |
| wdata_i | input | 9 | Write data, also the offset value while loading |
| wen_a_i | input | 1 | Write enable, first of pair |
| wen_b_i | input | 1 | Write enable, second of pair |
| load_i | input | 1 | Redirects write cycles into the offset registers |
| ren_a_i | input | 1 | Read enable, first of pair |
| ren_b_i | input | 1 | Read enable, second of pair |
| rdata_o | output | 9 | Last word read |
| empty_o | output | 1 | No words held (read domain) |
| aempty_o | output | 1 | Fill level at or below the almost-empty offset (read domain) |
| full_o | output | 1 | DEPTH words held (write domain) |
| afull_o | output | 1 | Fill level at or above DEPTH minus the almost-full offset (write domain) |

## Verification
Buffer traffic is driven with half-asserted enable pairs and with complete pairs. This separates the AND gating of each port from a single-enable decode. A full fill with a data pattern that changes in several bits per word, followed by a write while full and a complete drain, distinguishes correct ordering from overwrite on overflow. A read attempt on an empty buffer followed by one fresh word shows whether an underflowing read moved the pointer. The threshold flags are probed at the level just inside and just outside each threshold, for four offset settings. These settings are the defaults, a two-register load, a single-register partial load and a three-write wrapping load, and together they tell apart the sequencer order, the wrap and the reset restore.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  localparam int unsigned DATA_W         = 9;
  localparam int unsigned OFFSET_DEFAULT = 7;

  typedef enum logic {
    OFS_EMPTY_SIDE = 1'b0,
    OFS_FULL_SIDE  = 1'b1
  } ofs_side_e;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/dcfifo_mem.sv
module dcfifo_mem #(
  parameter int unsigned DW = 9,
  parameter int unsigned AW = 6
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned WORDS = 1 << AW;

  logic [DW-1:0] ram_q [WORDS];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge wclk_i) begin
    if (we_i) ram_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= ram_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/dcfifo_wctl.sv
module dcfifo_wctl
  import dcfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned PW    = 7,
  parameter int unsigned OW    = 7
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic [PW-1:0] rgray_sync_i,
  input  logic [OW-1:0] af_off_i,
  output logic          we_o,
  output logic [PW-2:0] waddr_o,
  output logic [PW-1:0] wbin_o,
  output logic [PW-1:0] wgray_o,
  output logic          full_o,
  output logic          afull_o
);
  logic [PW-1:0] wbin_q, wgray_q, wbin_nxt, rbin_s, wcount;
  logic          we;

  assign rbin_s   = PW'(gray2bin(32'(rgray_sync_i)));
  assign wcount   = wbin_q - rbin_s;
  assign full_o   = (wcount == PW'(DEPTH));
  assign afull_o  = (int'(wcount) + int'(af_off_i)) >= int'(DEPTH);
  assign we       = wr_req_i & ~full_o;
  assign wbin_nxt = wbin_q + PW'(we);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_q <= PW'(bin2gray(32'(wbin_nxt)));
    end
  end

  assign we_o    = we;
  assign waddr_o = wbin_q[PW-2:0];
  assign wbin_o  = wbin_q;
  assign wgray_o = wgray_q;
endmodule

// File: rtl/dcfifo_rctl.sv
module dcfifo_rctl
  import dcfifo_pkg::*;
#(
  parameter int unsigned PW = 7,
  parameter int unsigned OW = 7
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          rd_req_i,
  input  logic [PW-1:0] wgray_sync_i,
  input  logic [OW-1:0] ae_off_i,
  output logic          re_o,
  output logic [PW-2:0] raddr_o,
  output logic [PW-1:0] rbin_o,
  output logic [PW-1:0] rgray_o,
  output logic          empty_o,
  output logic          aempty_o
);
  logic [PW-1:0] rbin_q, rgray_q, rbin_nxt, wbin_s, rcount;
  logic          re;

  assign wbin_s   = PW'(gray2bin(32'(wgray_sync_i)));
  assign rcount   = wbin_s - rbin_q;
  assign empty_o  = (rcount == '0);
  assign aempty_o = int'(rcount) <= int'(ae_off_i);
  assign re       = rd_req_i & ~empty_o;
  assign rbin_nxt = rbin_q + PW'(re);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_nxt;
      rgray_q <= PW'(bin2gray(32'(rbin_nxt)));
    end
  end

  assign re_o    = re;
  assign raddr_o = rbin_q[PW-2:0];
  assign rbin_o  = rbin_q;
  assign rgray_o = rgray_q;
endmodule

// File: rtl/dcfifo_offsets.sv
module dcfifo_offsets
  import dcfifo_pkg::*;
#(
  parameter int unsigned OW = 7,
  parameter int unsigned LW = 7
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          wr_i,
  input  logic [LW-1:0] wdata_i,
  output logic [OW-1:0] ae_off_o,
  output logic [OW-1:0] af_off_o
);
  localparam int unsigned NCH  = (OW + LW - 1) / LW;
  localparam int unsigned NREG = 2 * NCH;
  localparam int unsigned IW   = (NREG > 1) ? $clog2(NREG) : 1;

  logic [IW-1:0] idx_q;
  logic [OW-1:0] ae_q, af_q, chunk_mask, chunk_data;
  ofs_side_e     side;
  int            chunk;
  logic          ld_wr;

  assign ld_wr      = load_i & wr_i;
  assign side       = (int'(idx_q) >= int'(NCH)) ? OFS_FULL_SIDE : OFS_EMPTY_SIDE;
  assign chunk      = int'(idx_q) % int'(NCH);
  assign chunk_mask = OW'((1 << LW) - 1) << (chunk * int'(LW));
  assign chunk_data = OW'(wdata_i) << (chunk * int'(LW));

  // sequencer restarts at the almost-empty offset whenever load drops
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (!load_i) idx_q <= '0;
    else if (wr_i)   idx_q <= (idx_q == IW'(NREG - 1)) ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_q <= OW'(OFFSET_DEFAULT);
      af_q <= OW'(OFFSET_DEFAULT);
    end else if (ld_wr) begin
      if (side == OFS_EMPTY_SIDE) ae_q <= (ae_q & ~chunk_mask) | chunk_data;
      else                        af_q <= (af_q & ~chunk_mask) | chunk_data;
    end
  end

  assign ae_off_o = ae_q;
  assign af_off_o = af_q;
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag
  import dcfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wen_a_i,
  input  logic              wen_b_i,
  input  logic              load_i,
  input  logic              ren_a_i,
  input  logic              ren_b_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_o,
  output logic              aempty_o,
  output logic              full_o,
  output logic              afull_o
);
  localparam int unsigned DW = DATA_W;
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;
  localparam int unsigned OW = $clog2(DEPTH + 1);
  localparam int unsigned LW = (OW < DW) ? OW : DW;

  logic          wr_both, rd_both, wr_req;
  logic          we, re;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wbin, rbin, wgray, rgray, wgray_s, rgray_s;
  logic [OW-1:0] ae_off, af_off;

  assign wr_both = wen_a_i & wen_b_i;
  assign rd_both = ren_a_i & ren_b_i;
  assign wr_req  = wr_both & ~load_i;

  dcfifo_offsets #(.OW(OW), .LW(LW)) u_ofs (
    .wclk_i  (wclk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .wr_i    (wr_both),
    .wdata_i (wdata_i[LW-1:0]),
    .ae_off_o(ae_off),
    .af_off_o(af_off)
  );

  dcfifo_wctl #(.DEPTH(DEPTH), .PW(PW), .OW(OW)) u_wctl (
    .wclk_i      (wclk_i),
    .rst_ni      (rst_ni),
    .wr_req_i    (wr_req),
    .rgray_sync_i(rgray_s),
    .af_off_i    (af_off),
    .we_o        (we),
    .waddr_o     (waddr),
    .wbin_o      (wbin),
    .wgray_o     (wgray),
    .full_o      (full_o),
    .afull_o     (afull_o)
  );

  dcfifo_rctl #(.PW(PW), .OW(OW)) u_rctl (
    .rclk_i      (rclk_i),
    .rst_ni      (rst_ni),
    .rd_req_i    (rd_both),
    .wgray_sync_i(wgray_s),
    .ae_off_i    (ae_off),
    .re_o        (re),
    .raddr_o     (raddr),
    .rbin_o      (rbin),
    .rgray_o     (rgray),
    .empty_o     (empty_o),
    .aempty_o    (aempty_o)
  );

  dcfifo_sync #(.W(PW)) u_sync_w2r (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .d_i   (wgray),
    .q_o   (wgray_s)
  );

  dcfifo_sync #(.W(PW)) u_sync_r2w (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .d_i   (rgray),
    .q_o   (rgray_s)
  );

  dcfifo_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk_i (wclk_i),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wdata_i),
    .rclk_i (rclk_i),
    .rst_ni (rst_ni),
    .re_i   (re),
    .raddr_i(raddr),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/dcfifo_pflag_chk.sv
module dcfifo_pflag_chk #(
  parameter int unsigned PW = 7,
  parameter int unsigned DW = 9
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          load_i,
  input logic          wr_both_i,
  input logic          rd_both_i,
  input logic          full_i,
  input logic          afull_i,
  input logic          empty_i,
  input logic          aempty_i,
  input logic [PW-1:0] wbin_i,
  input logic [PW-1:0] rbin_i,
  input logic [PW-1:0] wgray_i,
  input logic [DW-1:0] rdata_i
);
  a_r2_no_write_without_pair: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !wr_both_i |=> $stable(wbin_i));

  a_r8_load_blocks_write: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    load_i |=> $stable(wbin_i));

  a_r5_no_overflow: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_i |=> $stable(wbin_i));

  a_r1_gray_one_bit: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $onehot0(wgray_i ^ $past(wgray_i)));

  a_r3_no_read_without_pair: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !rd_both_i |=> $stable(rbin_i) && $stable(rdata_i));

  a_r4_no_underflow: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    empty_i |=> $stable(rbin_i) && $stable(rdata_i));

  a_r6_empty_within_aempty: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    empty_i |-> aempty_i);

  a_r7_full_within_afull: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_i |-> afull_i);
endmodule

bind dcfifo_pflag dcfifo_pflag_chk #(.PW(PW), .DW(DW)) u_chk (
  .wclk_i   (wclk_i),
  .rclk_i   (rclk_i),
  .rst_ni   (rst_ni),
  .load_i   (load_i),
  .wr_both_i(wr_both),
  .rd_both_i(rd_both),
  .full_i   (full_o),
  .afull_i  (afull_o),
  .empty_i  (empty_o),
  .aempty_i (aempty_o),
  .wbin_i   (wbin),
  .rbin_i   (rbin),
  .wgray_i  (wgray),
  .rdata_i  (rdata_o)
);

// File: tb/tb_dcfifo_pflag.sv
`timescale 1ns/100ps
module tb_dcfifo_pflag;
  localparam int DEPTH = 64;

  logic       wclk = 0, rclk = 0, rst_ni = 0;
  logic [8:0] wdata = '0;
  logic       wen_a = 0, wen_b = 0, load = 0, ren_a = 0, ren_b = 0;
  logic [8:0] rdata;
  logic       empty, aempty, full, afull;

  int n_chk = 0, n_bad = 0;
  logic [8:0] mq[$];
  logic [8:0] seq = 9'h011;

  always #2   wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  dcfifo_pflag #(.DEPTH(DEPTH)) dut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni),
    .wdata_i(wdata), .wen_a_i(wen_a), .wen_b_i(wen_b), .load_i(load),
    .ren_a_i(ren_a), .ren_b_i(ren_b), .rdata_o(rdata),
    .empty_o(empty), .aempty_o(aempty), .full_o(full), .afull_o(afull)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (6) @(negedge wclk);
  endtask

  task automatic push(input logic [8:0] d);
    @(negedge wclk);
    wdata = d; wen_a = 1; wen_b = 1;
    @(negedge wclk);
    wen_a = 0; wen_b = 0;
    if (!load && mq.size() < DEPTH) mq.push_back(d);
  endtask

  task automatic fill_to(input int n);
    while (mq.size() < n) begin
      push(seq);
      seq = seq + 9'd37;
    end
    settle();
  endtask

  task automatic pop_chk(input string tag);
    logic [8:0] exp;
    @(negedge rclk);
    ren_a = 1; ren_b = 1;
    @(negedge rclk);
    ren_a = 0; ren_b = 0;
    exp = mq.pop_front();
    chk(tag, rdata, exp);
  endtask

  task automatic drain(input string tag);
    settle();
    while (mq.size() > 0) pop_chk(tag);
    settle();
    chk({tag, " empty after drain"}, empty, 1);
  endtask

  task automatic do_reset();
    rst_ni = 0;
    repeat (3) @(negedge wclk);
    rst_ni = 1;
    mq.delete();
    settle();
  endtask

  task automatic t_reset_state();
    chk("R10 empty", empty, 1);
    chk("R10 aempty", aempty, 1);
    chk("R10 full", full, 0);
    chk("R10 afull", afull, 0);
    chk("R10 rdata", rdata, 0);
  endtask

  task automatic t_enable_pairs();
    @(negedge wclk); wdata = 9'h1C3; wen_a = 1;
    @(negedge wclk); wen_a = 0; wen_b = 1;
    @(negedge wclk); wen_b = 0;
    settle();
    chk("R2 single write enable stores nothing", empty, 0 + 1);
    push(9'h0A5);
    settle();
    chk("R2 paired enables store", empty, 0);
    @(negedge rclk); ren_a = 1;
    @(negedge rclk); ren_a = 0; ren_b = 1;
    @(negedge rclk); ren_b = 0;
    settle();
    chk("R3 single read enable rdata", rdata, 0);
    chk("R3 single read enable keeps word", empty, 0);
    drain("R3");
  endtask

  task automatic t_order_full();
    fill_to(DEPTH);
    chk("R5 full at depth", full, 1);
    chk("R7 afull at depth", afull, 1);
    push(9'h1FF);
    settle();
    chk("R5 still full", full, 1);
    drain("R1");
  endtask

  task automatic t_read_empty();
    logic [8:0] last;
    last = rdata;
    @(negedge rclk); ren_a = 1; ren_b = 1;
    @(negedge rclk); @(negedge rclk); ren_a = 0; ren_b = 0;
    chk("R4 rdata holds on empty read", rdata, last);
    chk("R4 empty holds", empty, 1);
    push(9'h055);
    settle();
    pop_chk("R4 next word after empty read");
  endtask

  task automatic t_flags(input int ae, input int af, input string te, input string tf);
    fill_to(ae);
    chk({te, " aempty at offset"}, aempty, 1);
    fill_to(ae + 1);
    chk({te, " aempty above offset"}, aempty, 0);
    fill_to(DEPTH - af - 1);
    chk({tf, " afull below level"}, afull, 0);
    fill_to(DEPTH - af);
    chk({tf, " afull at level"}, afull, 1);
    drain(te);
  endtask

  task automatic t_load_both();
    load = 1; push(9'd3); push(9'd10); load = 0;
    settle();
    chk("R8 load writes not buffered", empty, 1);
    t_flags(3, 10, "R8", "R8");
  endtask

  task automatic t_partial_load();
    load = 1; push(9'd5); load = 0;
    settle();
    t_flags(5, 10, "R9", "R9");
  endtask

  task automatic t_wrap_load();
    load = 1; push(9'd2); push(9'd4); push(9'd6); load = 0;
    settle();
    t_flags(6, 4, "R8 wrap", "R8 wrap");
  endtask

  task automatic t_reset_restore();
    fill_to(20);
    do_reset();
    chk("R10 empty after reset", empty, 1);
    t_flags(7, 7, "R10", "R10");
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    t_reset_state();
    t_enable_pairs();
    t_order_full();
    t_read_empty();
    t_flags(7, 7, "R6", "R7");
    t_load_both();
    t_partial_load();
    t_wrap_load();
    t_reset_restore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule